// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Nonmaskable Input

This block gathers twenty-two interrupt sources and presents a single winning request to the processor. The sources are an edge-sensed nonmaskable input, two active-low maskable lines and nineteen on-chip peripheral request lines. The nonmaskable request can also come from a watchdog overflow. Software sets per-group priority levels and per-source routing through eight byte registers in a fixed address window. A maskable request reaches the processor only when its level is above the processor's current 3-bit mask. A source whose routing bit is set goes to a data-transfer request output instead of the processor.

The processor sees a valid flag, a 5-bit vector number and a 4-bit level. It pulses an acknowledge when exception handling starts. The nonmaskable request stays latched until that acknowledge. When the acknowledge is taken, the block tells the processor to load mask 7 and to clear its trace bit. An edge that arrives after the clear queues the nonmaskable sequence again.

Top module: `prio_intc`

## Requirements
- R1: After reset all eight registers read 0x00, and neither `irq_valid` nor `dtc_valid` is asserted.
- R2: The registers are at addresses 0xFFF0 to 0xFFF7. Offsets 0 to 3 are priority registers A to D and offsets 4 to 7 are routing registers A to D. A write with `bus_we` high lands on the next clock edge. `bus_rdata` returns the addressed register combinationally. Outside the window it returns 0x00, and writes there change no register.
- R3: Vector 1 is IRQ0 (group 0). Vector 2 is IRQ1 (group 1). Peripheral line k is vector 3+k in group 2+k/4, using integer division. Priority register j holds group 2j in bits 6:4 and group 2j+1 in bits 2:0. A level of 0 disables the group.
- R4: A maskable request is presented only when its level is strictly greater than `cpu_mask`.
- R5: Among the eligible maskable requests, the highest level wins. Equal levels go to the lowest vector number.
- R6: The four routing registers form a 32-bit word, {D,C,B,A}. Bit v-1 set sends vector v to `dtc_valid`/`dtc_vector` instead of the processor output. The same mask and arbitration rules apply there.
- R7: IRQ0 and IRQ1 are active-low and level-sensitive. Each is synchronized by two flops, so a request appears two clock edges after the line changes.
- R8: The nonmaskable input is synchronized. With `nmi_rise_sel`=1 it triggers on a rising edge, and with 0 on a falling edge. The request is presented as vector 0 at level 8 on the third clock edge after the pin changes. It wins over every maskable request and ignores `cpu_mask`.
- R9: A `wdt_ovf` pulse latches a nonmaskable request on the next edge only when `wdt_tme` and `wdt_wt` are both 1.
- R10: The nonmaskable request stays presented until `ack` is sampled high while it is presented, and that acknowledge clears it. A later qualifying edge latches it again.
- R11: While `ack` is high with the nonmaskable request presented, `mask_wr` and `trace_clr` are 1 and `new_mask` is 7. Otherwise `mask_wr` and `trace_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| nmi_pin | input | 1 | Nonmaskable interrupt pin, asynchronous |
| nmi_rise_sel | input | 1 | 1 selects rising edge, 0 selects falling edge |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_tme | input | 1 | Watchdog timer-mode enable |
| wdt_wt | input | 1 | Watchdog mode select (1 = watchdog) |
| irq_n | input | 2 | Active-low external maskable lines |
| periph_req | input | 19 | On-chip peripheral requests |
| cpu_mask | input | 3 | Current processor mask level |
| ack | input | 1 | Exception handling start pulse |
| irq_valid | output | 1 | Interrupt presented to processor |
| irq_vector | output | 5 | Vector number of the presented interrupt |
| irq_level | output | 4 | Level of the presented interrupt |
| dtc_valid | output | 1 | Data-transfer request presented |
| dtc_vector | output | 5 | Vector number of the data-transfer request |
| mask_wr | output | 1 | Processor should load `new_mask` |
| new_mask | output | 3 | Mask to load on nonmaskable acceptance |
| trace_clr | output | 1 | Processor should clear its trace bit |

## Verification
Some results depend only on registered state, and these are combinational. Peripheral requests and register writes are visible one settled cycle after they are driven. The IRQ lines take two clock edges. A nonmaskable pin edge takes three edges, and a qualified watchdog pulse takes one. The vector table therefore applies each pattern and waits three edges before sampling at the falling clock edge. The directed nonmaskable tests sample after the second and after the third edge, so a design that is one cycle early or late is caught. The acceptance outputs are checked in the same cycle that `ack` is driven, before the edge that clears the latch.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NPERIPH = 19,
  parameter logic [15:0] BASE = 16'hFFF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 nmi_pin,
  input  logic                 nmi_rise_sel,
  input  logic                 wdt_ovf,
  input  logic                 wdt_tme,
  input  logic                 wdt_wt,
  input  logic [1:0]           irq_n,
  input  logic [NPERIPH-1:0]   periph_req,
  input  logic [2:0]           cpu_mask,
  input  logic                 ack,
  output logic                 irq_valid,
  output logic [4:0]           irq_vector,
  output logic [3:0]           irq_level,
  output logic                 dtc_valid,
  output logic [4:0]           dtc_vector,
  output logic                 mask_wr,
  output logic [2:0]           new_mask,
  output logic                 trace_clr
);
  localparam int NSRC = NPERIPH + 2;

  logic [7:0] regs [8];
  logic [1:0] irq_s0, irq_s1;
  logic       nmi_s0, nmi_s1, nmi_prev, nmi_pend;
  logic       nmi_evt, wdt_evt, nmi_take, in_win;
  logic [NSRC:1] src_req;
  logic [31:0]   dte_w;
  logic [2:0]  c_lvl, d_lvl;
  logic [4:0]  c_vec, d_vec;

  assign in_win  = bus_addr[15:3] == BASE[15:3];
  assign bus_rdata = in_win ? regs[bus_addr[2:0]] : 8'h00;
  assign src_req = {periph_req, ~irq_s1[1], ~irq_s1[0]};
  assign dte_w   = {regs[7], regs[6], regs[5], regs[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= 8'h00;
    end else if (bus_we && in_win) begin
      regs[bus_addr[2:0]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s0 <= 2'b11; irq_s1 <= 2'b11;
      nmi_s0 <= 1'b0;  nmi_s1 <= 1'b0; nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      irq_s0 <= irq_n;   irq_s1 <= irq_s0;
      nmi_s0 <= nmi_pin; nmi_s1 <= nmi_s0; nmi_prev <= nmi_s1;
      nmi_pend <= (nmi_pend & ~nmi_take) | nmi_evt | wdt_evt;
    end
  end

  assign nmi_evt = nmi_rise_sel ? (nmi_s1 & ~nmi_prev) : (~nmi_s1 & nmi_prev);
  assign wdt_evt = wdt_ovf & wdt_tme & wdt_wt;

  always_comb begin
    logic [2:0] g, lv;
    c_lvl = '0; c_vec = '0; d_lvl = '0; d_vec = '0;
    for (int v = 1; v <= NSRC; v++) begin
      g  = (v < 3) ? 3'(v - 1) : 3'(2 + (v - 3) / 4);
      lv = g[0] ? regs[g >> 1][2:0] : regs[g >> 1][6:4];
      if (src_req[v] && lv > cpu_mask) begin
        if (dte_w[v-1]) begin
          if (lv > d_lvl) begin d_lvl = lv; d_vec = 5'(v); end
        end else if (lv > c_lvl) begin
          c_lvl = lv; c_vec = 5'(v);
        end
      end
    end
  end

  assign irq_valid  = nmi_pend | (c_lvl != 3'd0);
  assign irq_vector = nmi_pend ? 5'd0 : c_vec;
  assign irq_level  = nmi_pend ? 4'd8 : {1'b0, c_lvl};
  assign dtc_valid  = d_lvl != 3'd0;
  assign dtc_vector = d_vec;
  assign nmi_take   = ack & nmi_pend;
  assign mask_wr    = nmi_take;
  assign trace_clr  = nmi_take;
  assign new_mask   = nmi_take ? 3'd7 : cpu_mask;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic [2:0] cpu_mask,
  input logic       irq_valid,
  input logic [4:0] irq_vector,
  input logic [3:0] irq_level,
  input logic       dtc_valid,
  input logic [4:0] dtc_vector,
  input logic       mask_wr,
  input logic [2:0] new_mask,
  input logic       trace_clr
);
  // R4
  mask_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level != 4'd8) |-> irq_level > {1'b0, cpu_mask});
  // R8
  nmi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 4'd8) |-> (irq_valid && irq_vector == 5'd0));
  // R10
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 4'd8 && !ack) |=> irq_level == 4'd8);
  // R11
  take_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |-> (trace_clr && new_mask == 3'd7 && irq_level == 4'd8 && ack));
  // R6
  route_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_valid && irq_valid) |-> dtc_vector != irq_vector);
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .cpu_mask(cpu_mask),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
  .dtc_valid(dtc_valid), .dtc_vector(dtc_vector),
  .mask_wr(mask_wr), .new_mask(new_mask), .trace_clr(trace_clr)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic nmi_pin = 0, nmi_rise_sel = 1, wdt_ovf = 0, wdt_tme = 0, wdt_wt = 0;
  logic [1:0] irq_n = 2'b11;
  logic [18:0] periph_req = '0;
  logic [2:0] cpu_mask = 0, new_mask;
  logic ack = 0;
  logic irq_valid, dtc_valid, mask_wr, trace_clr;
  logic [4:0] irq_vector, dtc_vector;
  logic [3:0] irq_level;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  prio_intc uut (.*);

  // periph, irq_n, mask | valid, vec, lvl | dtc valid, dtc vec
  localparam logic [39:0] TBL [12] = '{
    {19'h00000, 2'b11, 3'd0, 1'b0, 5'd0,  4'd0, 1'b0, 5'd0},
    {19'h00000, 2'b10, 3'd0, 1'b1, 5'd1,  4'd5, 1'b0, 5'd0},
    {19'h00000, 2'b01, 3'd0, 1'b1, 5'd2,  4'd3, 1'b0, 5'd0},
    {19'h00000, 2'b01, 3'd3, 1'b0, 5'd0,  4'd0, 1'b0, 5'd0},
    {19'h00000, 2'b00, 3'd0, 1'b1, 5'd1,  4'd5, 1'b0, 5'd0},
    {19'h00006, 2'b11, 3'd0, 1'b1, 5'd4,  4'd6, 1'b0, 5'd0},
    {19'h00020, 2'b11, 3'd0, 1'b0, 5'd0,  4'd0, 1'b0, 5'd0},
    {19'h02200, 2'b11, 3'd1, 1'b1, 5'd16, 4'd4, 1'b0, 5'd0},
    {19'h02000, 2'b10, 3'd4, 1'b1, 5'd1,  4'd5, 1'b0, 5'd0},
    {19'h20000, 2'b11, 3'd0, 1'b1, 5'd20, 4'd1, 1'b0, 5'd0},
    {19'h10000, 2'b11, 3'd0, 1'b0, 5'd0,  4'd0, 1'b1, 5'd19},
    {19'h10001, 2'b11, 3'd6, 1'b0, 5'd0,  4'd0, 1'b0, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    edges(2); rst_n = 1; edges(1);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      bus_addr = 16'hFFF0 + 16'(i); #1;
      chk("R1 reg reset", 32'(bus_rdata), 0);
    end
    chk("R1 irq_valid", 32'(irq_valid), 0);
    chk("R1 dtc_valid", 32'(dtc_valid), 0);

    // R2 register window; R3 level fields
    wr(16'hFFF0, 8'h53); wr(16'hFFF1, 8'h60); wr(16'hFFF2, 8'h24);
    wr(16'hFFF3, 8'h16); wr(16'hFFF6, 8'h04);
    wr(16'hFFE8, 8'hAA); wr(16'hFFF8, 8'hAA);
    bus_addr = 16'hFFF2; #1; chk("R2 readback", 32'(bus_rdata), 32'h24);
    bus_addr = 16'hFFF6; #1; chk("R2 routing readback", 32'(bus_rdata), 32'h04);
    bus_addr = 16'hFFF8; #1; chk("R2 outside read", 32'(bus_rdata), 0);
    bus_addr = 16'hFFF0; #1; chk("R2 outside write ignored", 32'(bus_rdata), 32'h53);

    // R3 R4 R5 R6 R7 table
    foreach (TBL[i]) begin
      @(negedge clk);
      {periph_req, irq_n, cpu_mask} = TBL[i][39:16];
      edges(3);
      chk("R3/R4/R5/R7 irq_valid", 32'(irq_valid), 32'(TBL[i][15]));
      if (TBL[i][15]) begin
        chk("R5 irq_vector", 32'(irq_vector), 32'(TBL[i][14:10]));
        chk("R4 irq_level", 32'(irq_level), 32'(TBL[i][9:6]));
      end
      chk("R6 dtc_valid", 32'(dtc_valid), 32'(TBL[i][5]));
      if (TBL[i][5]) chk("R6 dtc_vector", 32'(dtc_vector), 32'(TBL[i][4:0]));
    end

    // R7 two-edge synchronizer latency
    periph_req = '0; cpu_mask = 0; irq_n = 2'b11; edges(3);
    irq_n = 2'b10; edges(1);
    chk("R7 not after one edge", 32'(irq_valid), 0);
    edges(1);
    chk("R7 after two edges", 32'(irq_valid), 1);
    irq_n = 2'b11; edges(3);

    // R8 rising edge, mask 7, over maskable
    cpu_mask = 3'd7; irq_n = 2'b10; nmi_rise_sel = 1; nmi_pin = 1; edges(2);
    chk("R8 not after two edges", 32'(irq_level), 0);
    edges(1);
    chk("R8 level 8 after three edges", 32'(irq_level), 8);
    chk("R8 vector 0", 32'(irq_vector), 0);
    chk("R11 no mask_wr without ack", 32'(mask_wr), 0);
    edges(3);
    chk("R10 held until ack", 32'(irq_level), 8);
    // R11 acceptance
    ack = 1; #1;
    chk("R11 mask_wr", 32'(mask_wr), 1);
    chk("R11 trace_clr", 32'(trace_clr), 1);
    chk("R11 new_mask", 32'(new_mask), 7);
    edges(1); ack = 0; #1;
    chk("R10 cleared by ack", 32'(irq_valid), 0);
    // R10 requeue on new edge
    nmi_pin = 0; edges(4);
    chk("R8 falling ignored when rising selected", 32'(irq_valid), 0);
    nmi_pin = 1; edges(3);
    chk("R10 requeued", 32'(irq_level), 8);
    ack = 1; edges(1); ack = 0;

    // R8 falling-edge select
    nmi_rise_sel = 0; edges(2); nmi_pin = 0; edges(3);
    chk("R8 falling edge", 32'(irq_level), 8);
    ack = 1; edges(1); ack = 0; irq_n = 2'b11; cpu_mask = 0; edges(3);
    chk("R10 clear after falling", 32'(irq_valid), 0);

    // R9 watchdog qualification
    wdt_tme = 1; wdt_wt = 0; wdt_ovf = 1; edges(1); wdt_ovf = 0; #1;
    chk("R9 interval mode ignored", 32'(irq_valid), 0);
    wdt_wt = 1; wdt_ovf = 1; edges(1); wdt_ovf = 0; #1;
    chk("R9 watchdog NMI", 32'(irq_level), 8);
    ack = 1; edges(1); ack = 0; #1;
    chk("R9 cleared", 32'(irq_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule